// File: doc/BRIEF.md
# Programmable Watchdog Timer with Peripheral Reload

This block is a watchdog counter that sits among the functions of a multi-purpose I/O controller. Software programs it through four byte-wide configuration registers: a control register, a configuration register, and the low and high bytes of the count. A free-running 1 ms strobe from the chip is the time base. A prescaler turns that strobe into units of one second or one minute, and the configuration register picks the unit. The count register is 8 or 16 bits wide, set by a parameter. Writing the low count byte loads the whole count and starts the timer when the value is non-zero.

While the timer runs, four peripheral activity strobes can push the deadline back: game-port access, infrared-controller data, keyboard activity and mouse activity. Each source has its own enable bit in the control register. An accepted strobe does not reload at once. After a fixed number of 1 ms ticks, the counter is restored to the last written count and the prescaler restarts.

When the count reaches zero, or when software forces a timeout, the block sets a sticky status flag and stops. It then drives a keyboard-reset pulse and a power-good pulse, each only if its own configuration enable is set. Each pulse lasts a parameterised number of clock cycles.

Top module: `unit_watchdog`

## Requirements
- R1: After reset all four registers read 0x00, both pulse outputs are low and the timer is stopped.
- R2: Register indices are fixed: control 0x71, configuration 0x72, count low 0x73, count high 0x74. Configuration reads back as written, and its bits 3:0 appear on the interrupt-select output. Control reads {enables[7:4], 3'b000, status}. The count bytes read the live counter. Any other index reads 0x00.
- R3: With configuration bit 7 set, the unit is TICKS_PER_SEC tick strobes. Expiry occurs N units of counted ticks after a low-byte write of N; cycles with the tick input low do not advance the count.
- R4: With configuration bit 7 clear, the unit is TICKS_PER_SEC*SEC_PER_MIN ticks.
- R5: A low-byte write loads {latched high byte, written low byte} as the count and as the reload value. The high byte exists only when CNT_W is 16.
- R6: A low-byte write that yields a zero count stops the timer: the counter holds zero and no expiry follows.
- R7: Control bits 7, 6, 5 and 4 enable reload from the infrared, mouse, keyboard and game-port strobes (evt_i bits 3, 2, 1, 0). An enabled strobe while running restores the last written count RELOAD_TICKS ticks later and restarts the prescaler.
- R8: A strobe whose enable bit is clear has no effect on the timer.
- R9: On expiry, control bit 0 is set and the timer stops. The keyboard-reset output (enabled by configuration bit 6) and the power-good output (enabled by configuration bit 4) each go high for PULSE_CYC cycles, starting the cycle after the expiring edge.
- R10: Writing control with bit 1 set causes an immediate expiry with the same effects as a timeout.
- R11: The status bit is cleared only by writing 0x00 to the control register; any other control write leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 ms time-base strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register index for write and read |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| evt_i | input | 4 | Activity strobes: 0 game port, 1 keyboard, 2 mouse, 3 infrared |
| kbd_rst_o | output | 1 | Keyboard-reset pulse |
| pgood_pulse_o | output | 1 | Power-good pulse |
| irq_sel_o | output | 4 | Interrupt line selection |

## Verification
A low-byte write at edge E0 produces expiry at edge E0 + N*unit counted ticks. The pulse outputs are visible at the falling edge after that. The bench therefore counts falling edges from the write and compares the first high sample with its own formula. A strobe sampled at edge E0+t reloads at edge E0+t+RELOAD_TICKS, which moves expiry to E0+t+RELOAD_TICKS+N*unit. The bench keeps t far enough from the deadline that reload and expiry never share an edge. Register reads are combinational, so the bench samples them at the falling edge without spending a clock edge, and a forced timeout is checked at the first falling edge after the write.

// File: rtl/uwd_pkg.sv
package uwd_pkg;
  localparam logic [7:0] IDX_CTRL   = 8'h71;
  localparam logic [7:0] IDX_CFG    = 8'h72;
  localparam logic [7:0] IDX_CNT_LO = 8'h73;
  localparam logic [7:0] IDX_CNT_HI = 8'h74;

  localparam int CTRL_FORCE  = 1;
  localparam int CTRL_EN_LSB = 4;
  localparam int CFG_SEC     = 7;
  localparam int CFG_KRST    = 6;
  localparam int CFG_PGOOD   = 4;

  // length of one counting unit in tick strobes
  function automatic int unsigned unit_len(input logic sec,
                                           input int unsigned tps,
                                           input int unsigned spm);
    return sec ? tps : tps * spm;
  endfunction
endpackage

// File: rtl/uwd_regs.sv
module uwd_regs
  import uwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             expire_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [7:0]       rdata_o,
  output logic [3:0]       en_o,
  output logic             unit_sec_o,
  output logic             krst_en_o,
  output logic             pg_en_o,
  output logic [3:0]       irq_sel_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             force_o,
  output logic             status_o
);
  localparam bit HAS_HI = (CNT_W > 8);

  logic [3:0]  en_q;
  logic [7:0]  cfg_q;
  logic [7:0]  hi_q;
  logic        status_q;
  logic [15:0] cnt_pad;
  logic [15:0] full_val;
  logic        wr_ctrl, wr_ctrl_zero;

  assign wr_ctrl      = wr_i && (addr_i == IDX_CTRL);
  assign wr_ctrl_zero = wr_ctrl && (wdata_i == 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      cfg_q    <= '0;
      hi_q     <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_ctrl) en_q <= wdata_i[7:CTRL_EN_LSB];
      if (wr_i && addr_i == IDX_CFG) cfg_q <= wdata_i;
      if (HAS_HI && wr_i && addr_i == IDX_CNT_HI) hi_q <= wdata_i;
      if (expire_i)          status_q <= 1'b1;
      else if (wr_ctrl_zero) status_q <= 1'b0;
    end
  end

  assign full_val   = {hi_q, wdata_i};
  assign load_val_o = full_val[CNT_W-1:0];
  assign load_o     = wr_i && (addr_i == IDX_CNT_LO);
  assign force_o    = wr_ctrl && wdata_i[CTRL_FORCE];
  assign cnt_pad    = 16'(cnt_i);

  always_comb begin
    case (addr_i)
      IDX_CTRL:   rdata_o = {en_q, 3'b000, status_q};
      IDX_CFG:    rdata_o = cfg_q;
      IDX_CNT_LO: rdata_o = cnt_pad[7:0];
      IDX_CNT_HI: rdata_o = cnt_pad[15:8];
      default:    rdata_o = 8'h00;
    endcase
  end

  assign en_o       = en_q;
  assign unit_sec_o = cfg_q[CFG_SEC];
  assign krst_en_o  = cfg_q[CFG_KRST];
  assign pg_en_o    = cfg_q[CFG_PGOOD];
  assign irq_sel_o  = cfg_q[3:0];
  assign status_o   = status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_q && !wr_ctrl_zero |=> status_q); // R11
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_zero && !expire_i |=> !status_q); // R11
endmodule

// File: rtl/uwd_prescale.sv
module uwd_prescale
  import uwd_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SEC_PER_MIN   = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic unit_sec_i,
  output logic unit_pulse_o
);
  localparam int MAX_LEN = TICKS_PER_SEC * SEC_PER_MIN;
  localparam int PRE_W   = $clog2(MAX_LEN + 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  assign last = PRE_W'(unit_len(unit_sec_i, TICKS_PER_SEC, SEC_PER_MIN) - 1);
  assign unit_pulse_o = tick_i && run_i && !restart_i && (pre_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (tick_i)            pre_q <= unit_pulse_o ? '0 : pre_q + 1'b1;
  end

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_W'(MAX_LEN - 1)); // R4
endmodule

// File: rtl/uwd_reload_dly.sv
module uwd_reload_dly #(
  parameter int RELOAD_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [3:0] evt_i,
  input  logic [3:0] en_i,
  output logic       fire_o
);
  localparam int DLY_W = $clog2(RELOAD_TICKS + 1);

  logic             pend_q;
  logic [DLY_W-1:0] dly_q;
  logic             hit;

  assign hit    = run_i && (|(evt_i & en_i));
  assign fire_o = run_i && pend_q && tick_i && (dly_q == DLY_W'(RELOAD_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (!run_i) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
    end else if (!pend_q) begin
      if (hit) begin
        pend_q <= 1'b1;
        dly_q  <= '0;
      end
    end else if (tick_i) begin
      if (fire_o) pend_q <= 1'b0;
      else        dly_q  <= dly_q + 1'b1;
    end
  end

  AST_FIRE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !pend_q |=> !fire_o || (RELOAD_TICKS == 1)); // R7
endmodule

// File: rtl/uwd_counter.sv
module uwd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             force_i,
  input  logic             reload_i,
  input  logic             unit_pulse_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, rel_q;
  logic             run_q;

  assign expire_o = force_i ||
                    (run_q && unit_pulse_i && !reload_i && !load_i && cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      rel_q <= load_val_i;
      run_q <= (load_val_i != '0);
    end else if (force_i) begin
      run_q <= 1'b0;
    end else if (run_q && reload_i) begin
      cnt_q <= rel_q;
    end else if (run_q && unit_pulse_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && unit_pulse_i && !load_i && !force_i && !reload_i
    |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && reload_i && !load_i && !force_i |=> cnt_q == $past(rel_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !load_i |=> $stable(cnt_q) && !run_q); // R6
  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o && !load_i |=> !run_q); // R9
endmodule

// File: rtl/uwd_pulse.sv
module uwd_pulse #(
  parameter int PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic out_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  logic [PW-1:0] c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         c_q <= '0;
    else if (start_i)   c_q <= PW'(PULSE_CYC);
    else if (c_q != '0) c_q <= c_q - 1'b1;
  end

  assign out_o = (c_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> out_o); // R9
endmodule

// File: rtl/unit_watchdog.sv
module unit_watchdog #(
  parameter int CNT_W         = 16,
  parameter int TICKS_PER_SEC = 1000,
  parameter int SEC_PER_MIN   = 60,
  parameter int RELOAD_TICKS  = 5,
  parameter int PULSE_CYC     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic [3:0] evt_i,
  output logic       kbd_rst_o,
  output logic       pgood_pulse_o,
  output logic [3:0] irq_sel_o
);
  logic [3:0]       en;
  logic             unit_sec, krst_en, pg_en;
  logic             load, force_to, status;
  logic [CNT_W-1:0] load_val, cnt;
  logic             run, expire, reload_fire, unit_pulse;
  logic [1:0]       pulse_en, pulse_out;

  uwd_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .expire_i(expire), .cnt_i(cnt),
    .rdata_o(reg_rdata_o), .en_o(en), .unit_sec_o(unit_sec),
    .krst_en_o(krst_en), .pg_en_o(pg_en), .irq_sel_o(irq_sel_o),
    .load_o(load), .load_val_o(load_val), .force_o(force_to), .status_o(status)
  );

  uwd_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .restart_i(load || reload_fire), .unit_sec_i(unit_sec), .unit_pulse_o(unit_pulse)
  );

  uwd_reload_dly #(.RELOAD_TICKS(RELOAD_TICKS)) u_dly (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run),
    .evt_i(evt_i), .en_i(en), .fire_o(reload_fire)
  );

  uwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val),
    .force_i(force_to), .reload_i(reload_fire), .unit_pulse_i(unit_pulse),
    .cnt_o(cnt), .run_o(run), .expire_o(expire)
  );

  assign pulse_en = {pg_en, krst_en};

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    uwd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk(clk), .rst_n(rst_n), .start_i(expire && pulse_en[g]), .out_o(pulse_out[g])
    );
  end

  assign kbd_rst_o     = pulse_out[0];
  assign pgood_pulse_o = pulse_out[1];

  AST_KRST_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kbd_rst_o) |-> status); // R9
  AST_PGOOD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_pulse_o) |-> $past(pg_en)); // R9
endmodule

// File: tb/unit_watchdog_tb.sv
module unit_watchdog_tb;
  localparam int TPS = 10, SPM = 6, DLY = 5, PULSE = 4;
  localparam int USEC = TPS, UMIN = TPS * SPM;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [3:0] evt = 4'h0, irq_sel;
  logic kbd, pg;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  unit_watchdog #(.CNT_W(16), .TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM),
                  .RELOAD_TICKS(DLY), .PULSE_CYC(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .kbd_rst_o(kbd), .pgood_pulse_o(pg), .irq_sel_o(irq_sel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  // expected expiry offset from the low-byte write edge
  function automatic int exp_expiry(input int n, input int unit, input bit reload, input int t);
    return reload ? (t + DLY + n * unit) : (n * unit);
  endfunction

  task automatic measure(input int t_ev, input int src, input int off_s, input int off_l,
                         input int limit, output int kfirst, output int pfirst, output int kwidth);
    kfirst = 0; pfirst = 0; kwidth = 0;
    for (int k = 1; k <= limit; k++) begin
      evt  = (k == t_ev && src >= 0) ? 4'(1 << src) : 4'h0;
      tick = !(k >= off_s && k < off_s + off_l);
      @(negedge clk);
      if (kbd && kfirst == 0) kfirst = k;
      if (kbd) kwidth++;
      if (pg && pfirst == 0) pfirst = k;
    end
    evt = 4'h0; tick = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int v, kf, pf, kw, seed, n, t, src, mask, e;
    seed = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 8'h71; a <= 8'h74; a++) begin
      rd_reg(8'(a), v); chk(v == 0, "R1 reg after reset", v, 0);
    end
    chk(!kbd && !pg, "R1 outputs low", int'({kbd, pg}), 0);

    // R2 map and readback
    wr_reg(8'h72, 8'hD5);
    rd_reg(8'h72, v); chk(v == 8'hD5, "R2 cfg readback", v, 8'hD5);
    chk(irq_sel == 4'h5, "R2 irq select", int'(irq_sel), 5);
    rd_reg(8'h75, v); chk(v == 0, "R2 unmapped index", v, 0);
    wr_reg(8'h71, 8'hA0);
    rd_reg(8'h71, v); chk(v == 8'hA0, "R2 ctrl readback", v, 8'hA0);
    wr_reg(8'h71, 8'h00);

    // R3 / R9 seconds unit, both outputs enabled
    wr_reg(8'h72, 8'hD0);
    wr_reg(8'h74, 8'h00);
    wr_reg(8'h73, 8'd3);
    measure(0, -1, 0, 0, 60, kf, pf, kw);
    chk(kf == exp_expiry(3, USEC, 0, 0), "R3 seconds expiry", kf, 30);
    chk(pf == 30, "R9 power-good timing", pf, 30);
    chk(kw == PULSE, "R9 pulse width", kw, PULSE);
    rd_reg(8'h71, v); chk(v[0] == 1'b1, "R9 status set", v, 1);
    rd_reg(8'h73, v); chk(v == 0, "R9 counter stopped at zero", v, 0);

    // R11 status clear rules
    wr_reg(8'h71, 8'h80);
    rd_reg(8'h71, v); chk(v[0] == 1'b1, "R11 nonzero write keeps status", v, 8'h81);
    wr_reg(8'h71, 8'h00);
    rd_reg(8'h71, v); chk(v == 0, "R11 zero write clears status", v, 0);

    // R3 tick gating: 7 missing ticks delay expiry by 7 cycles
    wr_reg(8'h72, 8'hC0);
    wr_reg(8'h73, 8'd2);
    measure(0, -1, 5, 7, 40, kf, pf, kw);
    chk(kf == 27, "R3 tick gating", kf, 27);
    wr_reg(8'h71, 8'h00);

    // R4 / R9 minute unit, power-good disabled
    wr_reg(8'h72, 8'h40);
    wr_reg(8'h73, 8'd2);
    measure(0, -1, 0, 0, 140, kf, pf, kw);
    chk(kf == exp_expiry(2, UMIN, 0, 0), "R4 minute expiry", kf, 2 * UMIN);
    chk(pf == 0, "R9 power-good gated off", pf, 0);
    wr_reg(8'h71, 8'h00);

    // R5 16-bit count
    wr_reg(8'h72, 8'hC0);
    wr_reg(8'h74, 8'h01);
    wr_reg(8'h73, 8'h02);
    rd_reg(8'h73, v); chk(v == 2, "R5 count low", v, 2);
    rd_reg(8'h74, v); chk(v == 1, "R5 count high", v, 1);
    measure(0, -1, 0, 0, 2600, kf, pf, kw);
    chk(kf == 258 * USEC, "R5 16-bit expiry", kf, 258 * USEC);
    wr_reg(8'h71, 8'h00);

    // R6 stop
    wr_reg(8'h74, 8'h00);
    wr_reg(8'h73, 8'd5);
    measure(0, -1, 0, 0, 10, kf, pf, kw);
    wr_reg(8'h73, 8'h00);
    measure(0, -1, 0, 0, 100, kf, pf, kw);
    chk(kf == 0, "R6 no expiry after stop", kf, 0);
    rd_reg(8'h73, v); chk(v == 0, "R6 counter zero", v, 0);

    // R10 forced timeout
    wr_reg(8'h71, 8'h02);
    chk(kbd == 1'b1, "R10 force pulse", int'(kbd), 1);
    rd_reg(8'h71, v); chk(v[0] == 1'b1, "R10 force status", v, 1);
    repeat (PULSE) @(negedge clk);
    wr_reg(8'h71, 8'h00);

    // R7 enabled game-port reload
    wr_reg(8'h71, 8'h10);
    wr_reg(8'h73, 8'd3);
    measure(15, 0, 0, 0, 80, kf, pf, kw);
    chk(kf == exp_expiry(3, USEC, 1, 15), "R7 reload delays expiry", kf, 50);
    wr_reg(8'h71, 8'h00);

    // R8 disabled keyboard source
    wr_reg(8'h71, 8'h10);
    wr_reg(8'h73, 8'd3);
    measure(15, 1, 0, 0, 60, kf, pf, kw);
    chk(kf == 30, "R8 disabled source ignored", kf, 30);

    // R7 / R8 random sources, masks and times
    for (int i = 0; i < 20; i++) begin
      n    = 2 + int'($urandom_range(4));
      t    = 1 + int'($urandom_range(n * USEC - DLY - 2));
      src  = int'($urandom_range(3));
      mask = int'($urandom_range(15));
      e    = exp_expiry(n, USEC, mask[src], t);
      wr_reg(8'h71, 8'h00);
      wr_reg(8'h71, 8'(mask << 4));
      wr_reg(8'h73, 8'(n));
      measure(t, src, 0, 0, e + PULSE + 2, kf, pf, kw);
      chk(kf == e, mask[src] ? "R7 random reload" : "R8 random masked", kf, e);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule